// File: doc/BRIEF.md
# Serial Configuration Daisy-Chain Receiver

This block is the serial configuration input of one device that sits in a chain of devices sharing one configuration clock. Every device's serial output feeds the serial input of the next device, and one combined bitstream configures the whole chain. The block samples its serial input on each rising clock edge. It skips high filler bits until it finds a start pattern, then reads a length count. After the header it keeps a fixed, parameterised number of body bits for its own device. It sends every later body bit on to the next device.

Forwarded bits leave on the falling edge that follows the rising edge on which they were sampled. The next device therefore sees stable data around its own rising edge. Two sticky flags report progress. One reports that this device has taken all of its own bits. The other reports that the number of body bits received has reached the length count carried in the header.

Top module: `cfg_chain_rx`

## Requirements
- R1: While reset is low and right after it, ser_out is 1 and own_loaded and chain_done are 0.
- R2: The input is sampled on rising edges. The block looks for the start pattern 0,0,1,0 (first bit in time first) after any number of high filler bits, including none. A pattern that breaks off, such as 0,0,1,1, does not start a frame. No bit before the end of the start pattern is forwarded, and ser_out stays 1.
- R3: The 24 bits right after the start pattern are the length count, most significant bit first. They are not forwarded, and they are not counted as body bits.
- R4: The first OWN_BITS body bits are absorbed. ser_out stays 1 while they arrive and until own_loaded is set.
- R5: Body bit number OWN_BITS+1 and every later body bit appears on ser_out at the falling edge after the rising edge that sampled it. It is held there until the next falling edge.
- R6: own_loaded rises after the rising edge that samples body bit number OWN_BITS. It stays high until reset.
- R7: chain_done rises after the rising edge that samples body bit number N, where N is the length count and N >= 1. It stays high until reset, and forwarding continues past it.
- R8: Once the header is complete, start patterns inside the body are treated as data. The block does not look for a new header until it is reset.
- R9: An asynchronous reset in the middle of a frame brings ser_out back to 1 and clears both flags at once. The next frame is then parsed from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock shared by the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial configuration data in |
| ser_out | output | 1 | Retimed pass-through data to the next device, idle high |
| own_loaded | output | 1 | This device has taken all of its own bits |
| chain_done | output | 1 | Body bits received have reached the length count |

## Verification
A bit driven before rising edge k counts toward the header or the body at edge k. Both flags change at that same edge. A forwarded bit appears on ser_out half a period later, at the falling edge. The bench changes ser_in 2 ns after a falling edge. It reads ser_out and both flags 2 ns after the next falling edge, so every result it reads belongs to the bit it has just driven. The reset check is made while reset is still held low, with no clock edge in between.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
   typedef enum logic [1:0] {
      HS_HUNT = 2'd0,
      HS_LEN  = 2'd1,
      HS_BODY = 2'd2
   } hdr_state_t;
endpackage

// File: rtl/cfg_hdr_parse.sv
module cfg_hdr_parse
   import cfg_chain_pkg::*;
#(
   parameter int               LEN_W    = 24,
   parameter int               PRE_W    = 4,
   parameter logic [PRE_W-1:0] PREAMBLE = 4'b0010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic             in_body,
   output logic [LEN_W-1:0] length
);
   localparam int LCW = $clog2(LEN_W);
   localparam logic [LCW-1:0] LCNT_LAST = LCW'(LEN_W - 1);

   hdr_state_t       st;
   logic [PRE_W-1:0] win;
   logic [PRE_W-1:0] win_nxt;
   logic [LEN_W-1:0] len_q;
   logic [LCW-1:0]   lcnt;

   assign win_nxt = {win[PRE_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= HS_HUNT;
         win   <= '1;
         len_q <= '0;
         lcnt  <= '0;
      end else begin
         case (st)
            HS_HUNT: begin
               win <= win_nxt;
               if (win_nxt == PREAMBLE) begin
                  st   <= HS_LEN;
                  lcnt <= '0;
               end
            end
            HS_LEN: begin
               len_q <= {len_q[LEN_W-2:0], din};
               lcnt  <= lcnt + 1'b1;
               if (lcnt == LCNT_LAST) st <= HS_BODY;
            end
            default: st <= HS_BODY;
         endcase
      end
   end

   assign in_body = (st == HS_BODY);
   assign length  = len_q;
endmodule

// File: rtl/cfg_body_track.sv
module cfg_body_track #(
   parameter int LEN_W    = 24,
   parameter int OWN_BITS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_body,
   input  logic [LEN_W-1:0] length,
   output logic             fwd_now,
   output logic             loaded,
   output logic             done
);
   localparam logic [LEN_W-1:0] OWN_C    = LEN_W'(OWN_BITS);
   localparam logic [LEN_W-1:0] OWN_LAST = LEN_W'(OWN_BITS - 1);
   localparam logic [LEN_W-1:0] CNT_MAX  = '1;

   logic [LEN_W-1:0] cnt;
   logic [LEN_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt} + 1'b1;
   assign fwd_now = in_body && (cnt >= OWN_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         loaded <= 1'b0;
         done   <= 1'b0;
      end else if (in_body) begin
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         if (cnt == OWN_LAST) loaded <= 1'b1;
         if (cnt_inc >= {1'b0, length}) done <= 1'b1;
      end
   end
endmodule

// File: rtl/cfg_fwd_retime.sv
module cfg_fwd_retime #(
   parameter bit FALL_RETIME = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fwd_now,
   output logic cap_bit,
   output logic cap_fwd,
   output logic dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_bit <= 1'b1;
         cap_fwd <= 1'b0;
      end else begin
         cap_bit <= din;
         cap_fwd <= fwd_now;
      end
   end

   generate
      if (FALL_RETIME) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= cap_fwd ? cap_bit : 1'b1;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= cap_fwd ? cap_bit : 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
   parameter int               LEN_W       = 24,
   parameter int               PRE_W       = 4,
   parameter logic [PRE_W-1:0] PREAMBLE    = 4'b0010,
   parameter int               OWN_BITS    = 64,
   parameter bit               FALL_RETIME = 1'b1
) (
   input  logic cfg_clk,
   input  logic rst_n,
   input  logic ser_in,
   output logic ser_out,
   output logic own_loaded,
   output logic chain_done
);
   initial begin
      assert (LEN_W >= 2 && LEN_W <= 30)
         else $error("cfg_chain_rx: LEN_W out of range");
      assert (PRE_W >= 2 && PRE_W <= LEN_W)
         else $error("cfg_chain_rx: PRE_W out of range");
      assert (PREAMBLE != '1)
         else $error("cfg_chain_rx: start pattern must differ from filler");
      assert (OWN_BITS >= 1 && OWN_BITS < (1 << LEN_W))
         else $error("cfg_chain_rx: OWN_BITS does not fit the counter");
   end

   logic             in_body;
   logic [LEN_W-1:0] length;
   logic             fwd_now;
   logic             cap_bit;
   logic             cap_fwd;

   cfg_hdr_parse #(
      .LEN_W(LEN_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)
   ) u_hdr (
      .clk(cfg_clk), .rst_n(rst_n), .din(ser_in),
      .in_body(in_body), .length(length)
   );

   cfg_body_track #(
      .LEN_W(LEN_W), .OWN_BITS(OWN_BITS)
   ) u_body (
      .clk(cfg_clk), .rst_n(rst_n), .in_body(in_body), .length(length),
      .fwd_now(fwd_now), .loaded(own_loaded), .done(chain_done)
   );

   cfg_fwd_retime #(
      .FALL_RETIME(FALL_RETIME)
   ) u_ret (
      .clk(cfg_clk), .rst_n(rst_n), .din(ser_in), .fwd_now(fwd_now),
      .cap_bit(cap_bit), .cap_fwd(cap_fwd), .dout(ser_out)
   );
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk #(
   parameter bit FALL = 1'b1
) (
   input logic cfg_clk,
   input logic rst_n,
   input logic ser_out,
   input logic own_loaded,
   input logic chain_done,
   input logic in_body,
   input logic cap_bit,
   input logic cap_fwd
);
   p_idle_until_loaded_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !own_loaded |-> ser_out);

   p_loaded_sticky_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      own_loaded |=> own_loaded);

   p_done_sticky_r7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      chain_done |=> chain_done);

   p_no_rearm_r8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      in_body |=> in_body);

   p_flags_need_body_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !in_body |-> (!own_loaded && !chain_done));

   generate
      if (FALL) begin : g_fall_chk
         p_fwd_bit_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
            cap_fwd |-> (ser_out == cap_bit));
         p_hold_high_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
            !cap_fwd |-> ser_out);
      end
   endgenerate
endmodule

bind cfg_chain_rx cfg_chain_rx_chk #(.FALL(FALL_RETIME)) u_chk (
   .cfg_clk(cfg_clk), .rst_n(rst_n), .ser_out(ser_out),
   .own_loaded(own_loaded), .chain_done(chain_done),
   .in_body(in_body), .cap_bit(cap_bit), .cap_fwd(cap_fwd)
);

// File: tb/cfg_chain_rx_test.sv
module cfg_chain_rx_test;
   localparam int OWN = 8;
   localparam int LW  = 24;

   typedef struct packed {
      logic [7:0]    filler;
      logic [LW-1:0] len;
      logic [7:0]    pat;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{filler: 8'd3, len: 24'd12, pat: 8'hA5},
      '{filler: 8'd0, len: 24'd8,  pat: 8'h3C},
      '{filler: 8'd5, len: 24'd20, pat: 8'h96},
      '{filler: 8'd1, len: 24'd1,  pat: 8'h4D}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b1;
   logic dout, loaded, done;
   int   checks = 0;
   int   fails = 0;
   bit   ended = 1'b0;

   always #10 clk = ~clk;

   cfg_chain_rx #(.OWN_BITS(OWN)) uut (
      .cfg_clk(clk), .rst_n(rst_n), .ser_in(din),
      .ser_out(dout), .own_loaded(loaded), .chain_done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Leaves the bench 2 ns after a falling edge with reset released (R1).
   task automatic do_reset();
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      din   = 1'b1;
      #1;
      chk(dout == 1'b1, "R1 ser_out", dout, 1);
      chk(loaded == 1'b0 && done == 1'b0, "R1 flags", {loaded, done}, 0);
      @(negedge clk);
      #2;
      rst_n = 1'b1;
   endtask

   // Drive one bit, return ser_out 2 ns after the following falling edge.
   task automatic bit_io(input logic b, output logic o);
      din = b;
      @(posedge clk);
      @(negedge clk);
      #2;
      o = dout;
   endtask

   // Header-phase bits: never forwarded, no flag (R2, R3).
   task automatic send_hdr(input logic [31:0] v, input int n, input string req);
      logic o;
      for (int i = n - 1; i >= 0; i--) begin
         bit_io(v[i], o);
         chk(o == 1'b1, req, o, 1);
         chk(!done && !loaded, req, {loaded, done}, 0);
      end
   endtask

   task automatic send_frame_hdr(input int filler, input logic [LW-1:0] len);
      for (int i = 0; i < filler; i++) send_hdr(32'h1, 1, "R2 filler");
      send_hdr(32'b0010, 4, "R2 start");
      send_hdr({8'h0, len}, LW, "R3 length");
   endtask

   task automatic send_body(input int nbits, input int len, input logic [7:0] pat);
      logic o, b, exp_o;
      for (int i = 0; i < nbits; i++) begin
         b = pat[i % 8];
         bit_io(b, o);
         exp_o = (i >= OWN) ? b : 1'b1;
         if (i < OWN) chk(o == exp_o, "R4 absorb", o, exp_o);
         else         chk(o == exp_o, "R5 forward", o, exp_o);
         chk(loaded == (i >= OWN - 1), "R6 own_loaded", loaded, (i >= OWN - 1));
         chk(done == (i >= len - 1), "R7 chain_done", done, (i >= len - 1));
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // Vector table walk.
      for (int v = 0; v < 4; v++) begin
         do_reset();
         send_frame_hdr(int'(VECS[v].filler), VECS[v].len);
         send_body(int'(VECS[v].len) + 4, int'(VECS[v].len), VECS[v].pat);
      end

      // R2: broken pattern 0,0,1,1 must not start; real one follows.
      do_reset();
      send_hdr(32'b0011, 4, "R2 broken start");
      send_frame_hdr(0, 24'd10);
      send_body(14, 10, 8'h5A);

      // R8: body full of start patterns (0010 repeated = 8'h44 LSB-first order).
      do_reset();
      send_frame_hdr(2, 24'd16);
      send_body(20, 16, 8'b0100_0100);

      // R9: reset in the middle of forwarding, then a fresh frame.
      do_reset();
      send_frame_hdr(1, 24'd30);
      send_body(12, 30, 8'hC3);
      #1;
      rst_n = 1'b0;
      #1;
      chk(dout == 1'b1, "R9 ser_out after mid-frame reset", dout, 1);
      chk(!loaded && !done, "R9 flags after mid-frame reset", {loaded, done}, 0);
      @(negedge clk);
      #2;
      rst_n = 1'b1;
      send_frame_hdr(0, 24'd9);
      send_body(11, 9, 8'h71);

      finish_run();
   end
endmodule